// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO Controller

This block is a FIFO whose write side and read side run on two unrelated clocks. Words enter on the write clock and leave through a registered output on the read clock. A mode input is captured while the asynchronous master reset is held, and it picks one of two read behaviours. In standard mode every word, the first one included, must be fetched with an explicit read. In fall-through mode the oldest stored word moves into the output register by itself, and a read then consumes it.

Both pointers cross to the other clock domain as Gray codes through two-flop synchronisers. This fixes the flag latencies at a known number of destination-clock edges. The write side has active-low enable and chip-select inputs and one stop flag. The read side has active-low read enable and read select, an output-enable input and a status flag. The three-state output bus is modelled as a data bus plus a separate drive indication.

Back-pressure works as follows. A write is taken on a write-clock edge only when enable and select are both low and `wr_stop` is low. While `wr_stop` is high, write attempts are dropped, not held. A read is taken only when read enable and read select are both low and `rd_stat` shows that data is present. The producer must watch `wr_stop`, and the consumer must watch `rd_stat`.

Top module: `dual_mode_fifo`

## Requirements
- R1: `fall_mode` is captured while `mrst_n` is low (0 = standard, 1 = fall-through). Changing it after reset release has no effect until the next reset.
- R2: While reset is held, `rd_data` is 0 and `wr_stop` is 0. `rd_stat` is 0 in standard mode and 1 in fall-through mode.
- R3: In standard mode `rd_stat` = 1 means data is present. It rises on the second read-clock edge after the write-clock edge that stores a word into an empty FIFO. A read loads the next word into `rd_data` on its edge. `rd_stat` falls on the edge that reads the last word. Reads while `rd_stat` = 0 change nothing.
- R4: In fall-through mode, the first word written into an empty FIFO appears on `rd_data` on the third read-clock edge after its write edge. On that same edge `rd_stat` falls to 0 (0 = ready). This happens whatever the levels of `rd_en_n` and `rd_cs_n`.
- R5: In fall-through mode, a read on an edge where `rd_stat` = 0 replaces `rd_data` with the next word. If no word is left, `rd_stat` rises to 1 on that edge. Reads while `rd_stat` = 1 leave `rd_data` unchanged.
- R6: `wr_stop` rises on the write edge that fills the FIFO, and writes are dropped while it is high. Capacity is DEPTH words in standard mode and DEPTH+1 in fall-through mode, where the output register holds one word.
- R7: After a read frees a location in a full FIFO, `wr_stop` falls on the second write-clock edge after that read edge.
- R8: A read needs `rd_en_n` and `rd_cs_n` both low. With `rd_cs_n` high, `rd_data` and `rd_stat` hold in standard mode.
- R9: `rd_drive` is high only when `out_en_n` is low, and it follows `out_en_n` at once. Under that condition, `rd_drive` is high during reset and up to the first read-clock edge after it. After that, each read-clock edge sets `rd_drive` to the inverse of `rd_cs_n` sampled at that edge.
- R10: A word is stored only on a write-clock edge where `wr_en_n` and `wr_cs_n` are both low.
- R11: Words leave in the order they were accepted. No word is lost, duplicated or invented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| fall_mode | input | 1 | Read behaviour, captured during reset (1 = fall-through) |
| wr_en_n | input | 1 | Write enable, active low |
| wr_cs_n | input | 1 | Write select, active low |
| wr_data | input | DATA_W | Write data |
| wr_stop | output | 1 | High when full / not ready for input |
| rd_en_n | input | 1 | Read enable, active low |
| rd_cs_n | input | 1 | Read select, active low; sets output drive on each read edge |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rd_data | output | DATA_W | Output data register |
| rd_stat | output | 1 | Standard: 1 = data present; fall-through: 0 = word ready |
| rd_drive | output | 1 | High when the output bus would be driven |

## Verification
On every clock cycle, the embedded assertions check the following:
- the write pointer never moves while the stop flag is high or the write select is inactive;
- a standard-mode read never advances on an empty store;
- the output register holds while read select is inactive;
- a fall-through ready flag only drops after a real read;
- an active read select gives output drive on the next edge.

Only the bench's scenarios can show the rest. These are the exact edge counts of the flag latencies (two read edges, three for fall-through, two write edges for the stop flag), the two capacities, ordering through the scoreboard, and the drive behaviour around reset release.

// File: rtl/dcf_pkg.sv
`timescale 1ns/100ps
package dcf_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FALL = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dcf_gray_sync.sv
`timescale 1ns/100ps
// Two-flop synchroniser for a Gray-coded pointer.
module dcf_gray_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/100ps
// Storage array: written on the write clock, read combinationally.
module dcf_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/100ps
// Write-domain pointer and stop flag.
module dcf_wr_side #(
  parameter int AW = 3
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          wr_cs_n,
  input  logic [AW:0]   rgray_s,
  output logic          wr_we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          wr_stop
);
  logic [AW:0] wbin;
  logic [AW:0] wbin_nxt;

  // Full when the write pointer is one lap ahead of the synchronised read pointer.
  assign wr_stop  = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  assign wr_we    = !wr_en_n && !wr_cs_n && !wr_stop;
  assign wbin_nxt = wbin + {{AW{1'b0}}, wr_we};
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  a_r6_hold_when_full: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_stop |=> $stable(wbin));

  a_r10_cs_blocks_write: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_cs_n |=> $stable(wbin));
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/100ps
// Read-domain pointer, output register, status flag and output drive.
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int AW = 3,
  parameter int W  = 16
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fall_mode,
  input  logic          rd_en_n,
  input  logic          rd_cs_n,
  input  logic          out_en_n,
  input  logic [AW:0]   wgray_s,
  input  logic [W-1:0]  mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [W-1:0]  rd_data,
  output logic          rd_stat,
  output logic          rd_drive
);
  rd_mode_e    mode_q;
  logic [AW:0] rbin;
  logic [AW:0] rbin_nxt;
  logic        ovalid;
  logic        cs_q;
  logic        mem_empty;
  logic        rd_go;
  logic        true_read;
  logic        pop;

  assign mem_empty = (rgray == wgray_s);
  assign rd_go     = !rd_en_n && !rd_cs_n;
  assign true_read = rd_go && ovalid;

  always_comb begin
    if (mode_q == RD_STD) pop = rd_go && !mem_empty;
    else                  pop = !mem_empty && (!ovalid || true_read);
  end

  assign rbin_nxt = rbin + {{AW{1'b0}}, pop};
  assign raddr    = rbin[AW-1:0];

  // Mode is loaded while reset is asserted and frozen afterwards.
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) mode_q <= fall_mode ? RD_FALL : RD_STD;
    else        mode_q <= mode_q;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      rd_data <= '0;
      ovalid  <= 1'b0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      if (pop) rd_data <= mem_q;
      if (mode_q == RD_FALL) ovalid <= pop | (ovalid & ~true_read);
      else                   ovalid <= 1'b0;
    end
  end

  // Drive state: held on through reset, then follows the select each edge.
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= !rd_cs_n;
  end

  assign rd_stat  = (mode_q == RD_STD) ? !mem_empty : !ovalid;
  assign rd_drive = !out_en_n && cs_q;

  a_r3_no_read_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode_q == RD_STD && mem_empty) |=> $stable(rbin));

  a_r8_hold_without_cs: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode_q == RD_STD && rd_cs_n) |=> $stable(rd_data));

  a_r5_ready_drop_needs_read: assert property (@(posedge rclk) disable iff (!rst_n)
    (mode_q == RD_FALL && $fell(ovalid)) |-> $past(rd_go));

  a_r9_drive_after_select: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_cs_n |=> (rd_drive || out_en_n));
endmodule

// File: rtl/dual_mode_fifo.sv
`timescale 1ns/100ps
// Dual-clock FIFO with standard and fall-through read behaviour.
module dual_mode_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              fall_mode,
  input  logic              wr_en_n,
  input  logic              wr_cs_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_stop,
  input  logic              rd_en_n,
  input  logic              rd_cs_n,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_stat,
  output logic              rd_drive
);
  logic              we;
  logic [AW-1:0]     waddr;
  logic [AW-1:0]     raddr;
  logic [AW:0]       wgray;
  logic [AW:0]       rgray;
  logic [AW:0]       wgray_s;
  logic [AW:0]       rgray_s;
  logic [DATA_W-1:0] mem_q;

  dcf_wr_side #(.AW(AW)) u_wr (
    .wclk(wclk), .rst_n(mrst_n), .wr_en_n(wr_en_n), .wr_cs_n(wr_cs_n),
    .rgray_s(rgray_s), .wr_we(we), .waddr(waddr), .wgray(wgray), .wr_stop(wr_stop)
  );

  dcf_mem #(.W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_q)
  );

  dcf_gray_sync #(.N(AW + 1)) u_w2r (
    .clk(rclk), .rst_n(mrst_n), .d(wgray), .q(wgray_s)
  );

  dcf_gray_sync #(.N(AW + 1)) u_r2w (
    .clk(wclk), .rst_n(mrst_n), .d(rgray), .q(rgray_s)
  );

  dcf_rd_side #(.AW(AW), .W(DATA_W)) u_rd (
    .rclk(rclk), .rst_n(mrst_n), .fall_mode(fall_mode), .rd_en_n(rd_en_n),
    .rd_cs_n(rd_cs_n), .out_en_n(out_en_n), .wgray_s(wgray_s), .mem_q(mem_q),
    .raddr(raddr), .rgray(rgray), .rd_data(rd_data), .rd_stat(rd_stat),
    .rd_drive(rd_drive)
  );
endmodule

// File: tb/test_dual_mode_fifo.sv
`timescale 1ns/100ps
module test_dual_mode_fifo;
  logic        wclk = 1'b0;
  logic        rclk = 1'b0;
  logic        mrst_n = 1'b0;
  logic        fall_mode = 1'b0;
  logic        wr_en_n = 1'b1;
  logic        wr_cs_n = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_stop;
  logic        rd_en_n = 1'b1;
  logic        rd_cs_n = 1'b1;
  logic        out_en_n = 1'b0;
  logic [15:0] rd_data;
  logic        rd_stat;
  logic        rd_drive;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit mon_on = 0;
  bit mon_fall = 0;
  bit pend = 0;
  logic [15:0] pend_val = '0;
  logic [15:0] q[$];

  always #5 wclk = ~wclk;   // 100 MHz write clock
  always #8 rclk = ~rclk;   // independent read clock

  dual_mode_fifo #(.DATA_W(16), .DEPTH(8)) i_dual_mode_fifo (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .fall_mode(fall_mode),
    .wr_en_n(wr_en_n), .wr_cs_n(wr_cs_n), .wr_data(wr_data), .wr_stop(wr_stop),
    .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n), .out_en_n(out_en_n),
    .rd_data(rd_data), .rd_stat(rd_stat), .rd_drive(rd_drive)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor (R11): compares read results with accepted words.
  always @(negedge rclk) begin
    if (mon_on) begin
      if (!mon_fall) begin
        if (pend) chk("R11 order std", {16'h0, rd_data}, {16'h0, pend_val});
        pend = 0;
        if (!rd_en_n && !rd_cs_n && rd_stat) begin
          if (q.size() == 0) chk("R11 read with no expected word", 1, 0);
          else begin pend = 1; pend_val = q.pop_front(); end
        end
      end else if (!rd_stat) begin
        if (q.size() == 0) chk("R11 ready with no expected word", 1, 0);
        else begin
          chk("R11 order fall-through", {16'h0, rd_data}, {16'h0, q[0]});
          if (!rd_en_n && !rd_cs_n) void'(q.pop_front());
        end
      end
    end
  end

  task automatic do_reset(input logic fm);
    mon_on = 0; pend = 0; q.delete();
    mrst_n = 0; fall_mode = fm; rd_cs_n = 1; rd_en_n = 1;
    wr_en_n = 1; wr_cs_n = 0; out_en_n = 0;
    #30;
    chk("R2 status in reset", {31'h0, rd_stat}, {31'h0, fm});
    chk("R2 stop in reset", {31'h0, wr_stop}, 0);
    chk("R2 data in reset", {16'h0, rd_data}, 0);
    chk("R9 drive during reset", {31'h0, rd_drive}, 1);
    @(posedge rclk); #0.5;
    mrst_n = 1;
    chk("R9 drive before first edge", {31'h0, rd_drive}, 1);
    mon_fall = fm; mon_on = 1;
  endtask

  task automatic wr(input logic [15:0] d, input logic cs_n, input bit acc);
    @(posedge wclk); #0.5;
    wr_data = d; wr_cs_n = cs_n; wr_en_n = 0;
    @(posedge wclk); #0.5;
    wr_en_n = 1; wr_cs_n = 0;
    if (acc) q.push_back(d);
  endtask

  task automatic rd_burst(input int n);
    @(posedge rclk); #0.5;
    rd_en_n = 0;
    repeat (n) @(posedge rclk);
    #0.5;
    rd_en_n = 1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // ---------------- standard mode ----------------
    do_reset(1'b0);
    @(posedge rclk); #0.5;
    chk("R9 select high stops drive", {31'h0, rd_drive}, 0);
    rd_cs_n = 0;
    chk("R9 drive waits for edge", {31'h0, rd_drive}, 0);
    @(posedge rclk); #0.5;
    chk("R9 select low drives", {31'h0, rd_drive}, 1);
    out_en_n = 1; #0.2;
    chk("R9 out_en_n high forces off", {31'h0, rd_drive}, 0);
    out_en_n = 0;
    fall_mode = 1;  // R1: must not take effect before next reset

    wr(16'h1111, 1'b1, 0);
    repeat (4) @(posedge rclk); #0.5;
    chk("R10 write with select high ignored", {31'h0, rd_stat}, 0);

    wr(16'hA5A5, 1'b0, 1);
    @(posedge rclk); #0.5;
    chk("R3 R1 status after one read edge", {31'h0, rd_stat}, 0);
    @(posedge rclk); #0.5;
    chk("R3 R1 status after two read edges", {31'h0, rd_stat}, 1);

    rd_cs_n = 1;
    rd_burst(1);
    chk("R8 no read with select high data", {16'h0, rd_data}, 0);
    chk("R8 no read with select high status", {31'h0, rd_stat}, 1);
    rd_cs_n = 0;
    @(posedge rclk); #0.5;

    rd_burst(1);
    chk("R3 empty on last read edge", {31'h0, rd_stat}, 0);
    @(negedge rclk); #0.5;
    chk("R3 read data", {16'h0, rd_data}, 16'hA5A5);
    rd_burst(1);
    chk("R3 read while empty ignored", {16'h0, rd_data}, 16'hA5A5);

    for (int k = 0; k < 9; k++) begin
      wr(16'h0100 + 16'(k), 1'b0, k < 8);
      if (k == 7) chk("R6 stop on filling write std", {31'h0, wr_stop}, 1);
    end
    repeat (4) @(posedge rclk);
    rd_burst(1);
    chk("R7 stop held at read edge", {31'h0, wr_stop}, 1);
    @(posedge wclk); #0.5;
    chk("R7 stop after one write edge", {31'h0, wr_stop}, 1);
    @(posedge wclk); #0.5;
    chk("R7 stop clears after two write edges", {31'h0, wr_stop}, 0);
    wr(16'h0200, 1'b0, 1);
    repeat (4) @(posedge rclk);
    rd_burst(8);
    repeat (2) @(negedge rclk); #0.5;
    chk("R3 empty after draining", {31'h0, rd_stat}, 0);
    chk("R6 R11 dropped word absent", q.size(), 0);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    wr(16'hBEEF, 1'b0, 1);
    @(posedge rclk); #0.5;
    @(posedge rclk); #0.5;
    chk("R4 not ready after two edges", {31'h0, rd_stat}, 1);
    @(posedge rclk); #0.5;
    chk("R4 ready on third edge", {31'h0, rd_stat}, 0);
    chk("R4 word fell through with select high", {16'h0, rd_data}, 16'hBEEF);
    chk("R9 select high no drive", {31'h0, rd_drive}, 0);
    rd_cs_n = 0;
    @(posedge rclk); #0.5;
    chk("R9 drive after select edge", {31'h0, rd_drive}, 1);

    wr(16'hC001, 1'b0, 1);
    wr(16'hC002, 1'b0, 1);
    wr(16'hC003, 1'b0, 1);
    repeat (6) @(posedge rclk);
    rd_burst(4);
    chk("R5 not ready on edge consuming last", {31'h0, rd_stat}, 1);
    chk("R5 last word held", {16'h0, rd_data}, 16'hC003);
    rd_burst(1);
    chk("R5 read while not ready ignored", {16'h0, rd_data}, 16'hC003);

    wr(16'hF000, 1'b0, 1);
    repeat (5) @(posedge rclk);
    for (int k = 0; k < 9; k++) begin
      wr(16'hF100 + 16'(k), 1'b0, k < 8);
      if (k == 7) chk("R6 stop at depth plus one", {31'h0, wr_stop}, 1);
    end
    repeat (3) @(posedge rclk);
    rd_burst(9);
    repeat (2) @(negedge rclk); #0.5;
    chk("R5 not ready after draining", {31'h0, rd_stat}, 1);
    chk("R6 R11 fall-through extra word absent", q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule